// File: doc/BRIEF.md
# Paged Frame Buffer Window Mapper

This block lets a host processor reach a 512 x 512 frame store of 8-bit pixels through a 64 KB memory window. The frame store holds 256 KB. It is split into four 64 KB pages, and one page at a time is exposed in the window. The window sits in one of four fixed 64 KB segments of a 20-bit host address space. A board jumper level and a segment-select control bit choose that segment together.

The block watches every host read and write strobe. It claims a cycle only when the address falls in the chosen segment and the RAM-enable control bit is set. When that bit is clear, the block stays off the host bus, so several boards or other devices can share one segment. A claimed cycle is turned into a frame store address made from the page number and the window offset.

The address can be formed in one of two orders. In row order, consecutive host bytes run along a pixel row. In column order, the upper and lower halves of the address are swapped, so consecutive bytes run down a pixel column. The host bus strobes are plain level signals and need no handshake. A cycle is decoded in the same clock cycle that it is presented. Control fields are written through two one-cycle write strobes.

Top module: `fbw_window_mapper`

## Requirements
- R1: After reset, and while reset is held, both control registers are zero: page 0, row order, segment select 0, RAM disabled. No host cycle is claimed.
- R2: The window segment is address bits [19:16]. It equals 0xA when select=0 and jumper down, 0xB when select=0 and jumper up, 0xD when select=1 and jumper down, and 0xE when select=1 and jumper up. An address in any other segment is not claimed.
- R3: While RAM enable is 0, `host_hit`, `fs_we` and `fs_re` stay 0 and `host_rdata` is 0, whatever the address or strobes are.
- R4: A cycle is claimed only when `host_rd` or `host_wr` is 1. With both strobes low, `host_hit` is 0.
- R5: In row order (rotate=0), `fs_addr` = {page, host_addr[15:0]}, which is the linear offset page*65536 + window offset.
- R6: In column order (rotate=1), `fs_addr` is the 18-bit linear offset with its upper 9 bits and lower 9 bits swapped: {lin[8:0], lin[17:9]}.
- R7: `fs_re` = 1 and `host_rdata` = `fs_rdata` only on a claimed read with `host_wr` low. Otherwise `host_rdata` is 0.
- R8: `fs_we` = 1 exactly on a claimed cycle with `host_wr` = 1, and `fs_wdata` follows `host_wdata`. When both strobes are high, the cycle is a write and `fs_re` stays 0.
- R9: `ctl0_we` loads {rotate, page} from `ctl0_wdata` (page in bits [1:0], rotate in bit 2). `ctl1_we` loads `ctl1_wdata` (segment select in bit 0, RAM enable in bit 1). Each new value takes effect on the cycle after the strobe's clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ctl0_we | input | 1 | Write strobe for the page/rotate register |
| ctl0_wdata | input | 3 | {rotate, page[1:0]} |
| ctl1_we | input | 1 | Write strobe for the bus register |
| ctl1_wdata | input | 2 | {ram_enable, segment_select} |
| jumper_up | input | 1 | Board jumper level, 1 = up |
| host_addr | input | 20 | Host memory address |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 8 | Host write data |
| fs_rdata | input | 8 | Read data from the frame store |
| fs_addr | output | 18 | Frame store byte address |
| fs_we | output | 1 | Frame store write enable |
| fs_re | output | 1 | Frame store read enable and host data drive enable |
| fs_wdata | output | 8 | Frame store write data |
| host_hit | output | 1 | Cycle claimed by this block |
| host_rdata | output | 8 | Read data to host, 0 when not driving |

## Verification
The host-side outputs (`host_hit`, `fs_addr`, `fs_we`, `fs_re`, `host_rdata`) respond in the same cycle as the address and strobes. The bench therefore drives them on a falling edge and samples a quarter period later, before the next rising edge. Control writes take one rising edge to act. The bench checks the old behaviour before that edge and the new behaviour in the low phase after it. Reset works the same way: the claim goes away at the first rising edge with reset high.

// File: rtl/fbw_pkg.sv
package fbw_pkg;

  // Page/rotate register contents
  typedef struct packed {
    logic       rotate;
    logic [1:0] page;
  } view_cfg_t;

  // Bus connection register contents
  typedef struct packed {
    logic ram_en;
    logic seg_sel;
  } bus_cfg_t;

  // Index into the four-entry segment choice: {select, jumper}
  function automatic logic [1:0] seg_index(input logic sel, input logic jumper);
    return {sel, jumper};
  endfunction

endpackage

// File: rtl/fbw_ctrl_regs.sv
module fbw_ctrl_regs #(
  parameter int PAGE_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl0_we,
  input  logic [PAGE_W:0]   ctl0_wdata,
  input  logic              ctl1_we,
  input  logic [1:0]        ctl1_wdata,
  output logic [PAGE_W-1:0] page,
  output logic              rotate,
  output logic              seg_sel,
  output logic              ram_en
);

  logic [PAGE_W-1:0] page_q;
  logic              rotate_q;
  logic              seg_sel_q;
  logic              ram_en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      page_q   <= '0;
      rotate_q <= 1'b0;
    end else if (ctl0_we) begin
      page_q   <= ctl0_wdata[PAGE_W-1:0];
      rotate_q <= ctl0_wdata[PAGE_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seg_sel_q <= 1'b0;
      ram_en_q  <= 1'b0;
    end else if (ctl1_we) begin
      seg_sel_q <= ctl1_wdata[0];
      ram_en_q  <= ctl1_wdata[1];
    end
  end

  assign page    = page_q;
  assign rotate  = rotate_q;
  assign seg_sel = seg_sel_q;
  assign ram_en  = ram_en_q;

endmodule

// File: rtl/fbw_window_decode.sv
module fbw_window_decode
  import fbw_pkg::*;
#(
  parameter int         SEG_W     = 4,
  parameter logic [3:0] SEG_S0_DN = 4'hA,
  parameter logic [3:0] SEG_S0_UP = 4'hB,
  parameter logic [3:0] SEG_S1_DN = 4'hD,
  parameter logic [3:0] SEG_S1_UP = 4'hE
) (
  input  logic [SEG_W-1:0] addr_seg,
  input  logic             seg_sel,
  input  logic             jumper_up,
  input  logic             ram_en,
  input  logic             rd,
  input  logic             wr,
  output logic             hit
);

  localparam int NCHOICE = 4;

  logic [SEG_W-1:0] choice [NCHOICE];
  logic [SEG_W-1:0] base_seg;

  // Table of candidate segments, indexed by {select, jumper}
  generate
    for (genvar k = 0; k < NCHOICE; k++) begin : g_choice
      localparam logic [3:0] SEGV = (k == 0) ? SEG_S0_DN :
                                    (k == 1) ? SEG_S0_UP :
                                    (k == 2) ? SEG_S1_DN : SEG_S1_UP;
      assign choice[k] = SEGV[SEG_W-1:0];
    end
  endgenerate

  assign base_seg = choice[seg_index(seg_sel, jumper_up)];
  assign hit      = ram_en && (rd || wr) && (addr_seg == base_seg);

endmodule

// File: rtl/fbw_addr_former.sv
module fbw_addr_former #(
  parameter int OFF_W  = 16,
  parameter int PAGE_W = 2
) (
  input  logic [PAGE_W-1:0]       page,
  input  logic [OFF_W-1:0]        offset,
  input  logic                    rotate,
  output logic [PAGE_W+OFF_W-1:0] fs_addr
);

  localparam int LIN_W  = PAGE_W + OFF_W;
  localparam int HALF_W = LIN_W / 2;

  logic [LIN_W-1:0] lin;
  logic [LIN_W-1:0] swapped;

  assign lin = {page, offset};

  // Exchange the two halves: row index and column index trade places
  generate
    for (genvar i = 0; i < HALF_W; i++) begin : g_swap
      assign swapped[i]          = lin[i + HALF_W];
      assign swapped[i + HALF_W] = lin[i];
    end
  endgenerate

  assign fs_addr = rotate ? swapped : lin;

endmodule

// File: rtl/fbw_window_mapper.sv
module fbw_window_mapper #(
  parameter int         ADDR_W    = 20,
  parameter int         DATA_W    = 8,
  parameter int         PAGE_W    = 2,
  parameter logic [3:0] SEG_S0_DN = 4'hA,
  parameter logic [3:0] SEG_S0_UP = 4'hB,
  parameter logic [3:0] SEG_S1_DN = 4'hD,
  parameter logic [3:0] SEG_S1_UP = 4'hE
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     ctl0_we,
  input  logic [PAGE_W:0]          ctl0_wdata,
  input  logic                     ctl1_we,
  input  logic [1:0]               ctl1_wdata,
  input  logic                     jumper_up,
  input  logic [ADDR_W-1:0]        host_addr,
  input  logic                     host_rd,
  input  logic                     host_wr,
  input  logic [DATA_W-1:0]        host_wdata,
  input  logic [DATA_W-1:0]        fs_rdata,
  output logic [PAGE_W+ADDR_W-5:0] fs_addr,
  output logic                     fs_we,
  output logic                     fs_re,
  output logic [DATA_W-1:0]        fs_wdata,
  output logic                     host_hit,
  output logic [DATA_W-1:0]        host_rdata
);

  localparam int SEG_W = 4;
  localparam int OFF_W = ADDR_W - SEG_W;

  logic [PAGE_W-1:0] page;
  logic              rotate;
  logic              seg_sel;
  logic              ram_en;

  fbw_ctrl_regs #(.PAGE_W(PAGE_W)) regs_i (
    .clk        (clk),
    .rst        (rst),
    .ctl0_we    (ctl0_we),
    .ctl0_wdata (ctl0_wdata),
    .ctl1_we    (ctl1_we),
    .ctl1_wdata (ctl1_wdata),
    .page       (page),
    .rotate     (rotate),
    .seg_sel    (seg_sel),
    .ram_en     (ram_en)
  );

  fbw_window_decode #(
    .SEG_W     (SEG_W),
    .SEG_S0_DN (SEG_S0_DN),
    .SEG_S0_UP (SEG_S0_UP),
    .SEG_S1_DN (SEG_S1_DN),
    .SEG_S1_UP (SEG_S1_UP)
  ) decode_i (
    .addr_seg  (host_addr[ADDR_W-1:OFF_W]),
    .seg_sel   (seg_sel),
    .jumper_up (jumper_up),
    .ram_en    (ram_en),
    .rd        (host_rd),
    .wr        (host_wr),
    .hit       (host_hit)
  );

  fbw_addr_former #(.OFF_W(OFF_W), .PAGE_W(PAGE_W)) former_i (
    .page    (page),
    .offset  (host_addr[OFF_W-1:0]),
    .rotate  (rotate),
    .fs_addr (fs_addr)
  );

  // Write takes priority when both strobes are present
  assign fs_we      = host_hit && host_wr;
  assign fs_re      = host_hit && host_rd && !host_wr;
  assign fs_wdata   = host_wdata;
  assign host_rdata = fs_re ? fs_rdata : '0;

endmodule

// File: rtl/fbw_window_mapper_chk.sv
module fbw_window_mapper_chk #(
  parameter int         ADDR_W    = 20,
  parameter int         DATA_W    = 8,
  parameter int         PAGE_W    = 2,
  parameter logic [3:0] SEG_S0_DN = 4'hA,
  parameter logic [3:0] SEG_S0_UP = 4'hB,
  parameter logic [3:0] SEG_S1_DN = 4'hD,
  parameter logic [3:0] SEG_S1_UP = 4'hE
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] host_addr,
  input logic              host_rd,
  input logic              host_wr,
  input logic              host_hit,
  input logic              fs_we,
  input logic              fs_re,
  input logic [DATA_W-1:0] host_rdata,
  input logic              ram_en,
  input logic              seg_sel,
  input logic [PAGE_W-1:0] page,
  input logic              rotate,
  input logic              ctl0_we,
  input logic [PAGE_W:0]   ctl0_wdata,
  input logic              ctl1_we,
  input logic [1:0]        ctl1_wdata
);

  logic [3:0] seg;
  assign seg = host_addr[ADDR_W-1:ADDR_W-4];

  a_r1_reset_clears: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!ram_en && !seg_sel && !rotate && page == '0));

  a_r2_in_segment: assert property (@(posedge clk) disable iff (rst)
    host_hit |-> (seg == SEG_S0_DN || seg == SEG_S0_UP ||
                  seg == SEG_S1_DN || seg == SEG_S1_UP));

  a_r3_gated_off: assert property (@(posedge clk) disable iff (rst)
    !ram_en |-> (!host_hit && !fs_we && !fs_re));

  a_r4_needs_strobe: assert property (@(posedge clk) disable iff (rst)
    host_hit |-> (host_rd || host_wr));

  a_r7_quiet_data: assert property (@(posedge clk) disable iff (rst)
    !fs_re |-> (host_rdata == '0));

  a_r8_write_claim: assert property (@(posedge clk) disable iff (rst)
    fs_we |-> (host_hit && host_wr && !fs_re));

  a_r9_bus_load: assert property (@(posedge clk) disable iff (rst)
    ctl1_we |=> (ram_en == $past(ctl1_wdata[1]) && seg_sel == $past(ctl1_wdata[0])));

  a_r9_view_load: assert property (@(posedge clk) disable iff (rst)
    ctl0_we |=> (page == $past(ctl0_wdata[PAGE_W-1:0]) && rotate == $past(ctl0_wdata[PAGE_W])));

endmodule

bind fbw_window_mapper fbw_window_mapper_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W),
  .SEG_S0_DN(SEG_S0_DN), .SEG_S0_UP(SEG_S0_UP),
  .SEG_S1_DN(SEG_S1_DN), .SEG_S1_UP(SEG_S1_UP)
) chk_i (
  .clk        (clk),
  .rst        (rst),
  .host_addr  (host_addr),
  .host_rd    (host_rd),
  .host_wr    (host_wr),
  .host_hit   (host_hit),
  .fs_we      (fs_we),
  .fs_re      (fs_re),
  .host_rdata (host_rdata),
  .ram_en     (ram_en),
  .seg_sel    (seg_sel),
  .page       (page),
  .rotate     (rotate),
  .ctl0_we    (ctl0_we),
  .ctl0_wdata (ctl0_wdata),
  .ctl1_we    (ctl1_we),
  .ctl1_wdata (ctl1_wdata)
);

// File: tb/fbw_window_mapper_tb_top.sv
module fbw_window_mapper_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] RDV = 8'h5A;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ctl0_we = 1'b0;
  logic [2:0]  ctl0_wdata = '0;
  logic        ctl1_we = 1'b0;
  logic [1:0]  ctl1_wdata = '0;
  logic        jumper_up = 1'b0;
  logic [19:0] host_addr = '0;
  logic        host_rd = 1'b0;
  logic        host_wr = 1'b0;
  logic [7:0]  host_wdata = 8'hC3;
  logic [7:0]  fs_rdata = RDV;
  logic [17:0] fs_addr;
  logic        fs_we;
  logic        fs_re;
  logic [7:0]  fs_wdata;
  logic        host_hit;
  logic [7:0]  host_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fbw_window_mapper dut_i (
    .clk(clk), .rst(rst),
    .ctl0_we(ctl0_we), .ctl0_wdata(ctl0_wdata),
    .ctl1_we(ctl1_we), .ctl1_wdata(ctl1_wdata),
    .jumper_up(jumper_up), .host_addr(host_addr),
    .host_rd(host_rd), .host_wr(host_wr), .host_wdata(host_wdata),
    .fs_rdata(fs_rdata), .fs_addr(fs_addr), .fs_we(fs_we), .fs_re(fs_re),
    .fs_wdata(fs_wdata), .host_hit(host_hit), .host_rdata(host_rdata)
  );

  typedef struct packed {
    logic [2:0]  r0;    // {rotate, page}
    logic [1:0]  r1;    // {ram_en, seg_sel}
    logic        jmp;
    logic [19:0] addr;
    logic        rd;
    logic        wr;
    logic        hit;
    logic [17:0] fa;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{3'b000, 2'b11, 1'b1, 20'hE1234, 1'b1, 1'b0, 1'b1, 18'h01234}, // R2 R5 R7
    '{3'b011, 2'b10, 1'b0, 20'hAFFFF, 1'b0, 1'b1, 1'b1, 18'h3FFFF}, // R5 R8
    '{3'b011, 2'b10, 1'b0, 20'hBFFFF, 1'b1, 1'b0, 1'b0, 18'h3FFFF}, // R2 miss
    '{3'b001, 2'b10, 1'b1, 20'hB0200, 1'b1, 1'b0, 1'b1, 18'h10200}, // R2 R5
    '{3'b101, 2'b10, 1'b1, 20'hB0200, 1'b1, 1'b0, 1'b1, 18'h00081}, // R6
    '{3'b110, 2'b11, 1'b0, 20'hD0005, 1'b0, 1'b1, 1'b1, 18'h00B00}, // R6 R8
    '{3'b000, 2'b01, 1'b0, 20'hD0000, 1'b1, 1'b0, 1'b0, 18'h00000}, // R3
    '{3'b000, 2'b11, 1'b0, 20'hD0010, 1'b0, 1'b0, 1'b0, 18'h00010}, // R4
    '{3'b000, 2'b11, 1'b1, 20'hE0001, 1'b1, 1'b1, 1'b1, 18'h00001}  // R8 both strobes
  };

  task automatic check_val(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_ctl(input logic [2:0] r0, input logic [1:0] r1);
    @(negedge clk);
    ctl0_we = 1'b1; ctl0_wdata = r0;
    ctl1_we = 1'b1; ctl1_wdata = r1;
    @(negedge clk);
    ctl0_we = 1'b0; ctl1_we = 1'b0;
  endtask

  task automatic bus(input logic j, input logic [19:0] a, input logic rd, input logic wr);
    jumper_up = j; host_addr = a; host_rd = rd; host_wr = wr;
    #(CLK_PERIOD/4);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // Reset state: an otherwise valid segment-A read is not claimed
    repeat (3) @(negedge clk);
    bus(1'b0, 20'hA0000, 1'b1, 1'b0);
    check_val("R1 hit in reset", {31'd0, host_hit}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    bus(1'b0, 20'hA0000, 1'b1, 1'b0);
    check_val("R1 hit after reset", {31'd0, host_hit}, 32'd0);
    check_val("R1 rdata after reset", {24'd0, host_rdata}, 32'd0);
    check_val("R1 fs_addr after reset", {14'd0, fs_addr}, 32'h00000);

    // Vector table
    for (int v = 0; v < NV; v++) begin
      logic exp_we;
      logic exp_re;
      bus(1'b0, 20'h00000, 1'b0, 1'b0);
      set_ctl(VECS[v].r0, VECS[v].r1);
      bus(VECS[v].jmp, VECS[v].addr, VECS[v].rd, VECS[v].wr);
      exp_we = VECS[v].hit && VECS[v].wr;
      exp_re = VECS[v].hit && VECS[v].rd && !VECS[v].wr;
      check_val($sformatf("R2/R3/R4 hit vec%0d", v), {31'd0, host_hit}, {31'd0, VECS[v].hit});
      check_val($sformatf("R5/R6 fs_addr vec%0d", v), {14'd0, fs_addr}, {14'd0, VECS[v].fa});
      check_val($sformatf("R8 fs_we vec%0d", v), {31'd0, fs_we}, {31'd0, exp_we});
      check_val($sformatf("R7 rdata vec%0d", v), {24'd0, host_rdata}, exp_re ? {24'd0, RDV} : 32'd0);
      if (exp_we)
        check_val($sformatf("R8 fs_wdata vec%0d", v), {24'd0, fs_wdata}, {24'd0, host_wdata});
    end

    // R9: a control write acts only after its clock edge
    set_ctl(3'b000, 2'b00);
    bus(1'b0, 20'hA0042, 1'b1, 1'b0);
    ctl1_we = 1'b1; ctl1_wdata = 2'b10;
    #(CLK_PERIOD/8);
    check_val("R9 before edge", {31'd0, host_hit}, 32'd0);
    @(negedge clk);
    ctl1_we = 1'b0;
    #(CLK_PERIOD/4);
    check_val("R9 after edge", {31'd0, host_hit}, 32'd1);
    check_val("R9 rdata after edge", {24'd0, host_rdata}, {24'd0, RDV});

    // R3: RAM disable overrides an in-segment write with both strobes
    set_ctl(3'b111, 2'b00);
    bus(1'b0, 20'hA7777, 1'b1, 1'b1);
    check_val("R3 no write when disabled", {31'd0, fs_we}, 32'd0);
    check_val("R3 no read when disabled", {31'd0, fs_re}, 32'd0);

    // R1: reset in mid-run drops a live claim
    set_ctl(3'b010, 2'b11);
    bus(1'b1, 20'hE0100, 1'b1, 1'b0);
    check_val("R1 live claim before reset", {31'd0, host_hit}, 32'd1);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    #(CLK_PERIOD/4);
    check_val("R1 claim dropped by reset", {31'd0, host_hit}, 32'd0);
    check_val("R1 page cleared by reset", {14'd0, fs_addr}, 32'h00100);
    rst = 1'b0;
    host_rd = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule